// File: doc/BRIEF.md
# Prioritized Interrupt Level Resolver with Non-Maskable Source

This block decides which interrupt a processor core should service next. It keeps one request bit per interrupt line and masks the requests with a per-line enable vector. Each line has a fixed priority level, and the block compares the requests against the core's current interrupt level. From this it reports whether an interrupt is pending, the level of the winner and the index of the line that is taken. One line can be marked non-maskable. That source ignores the enable vector and the exception-mode flag, and it can always preempt because the level threshold is clamped below its level.

Request bits come in three kinds. A level-type bit follows its input line. An edge-type bit latches a rising edge and is cleared only by a software clear pulse. The non-maskable bit latches a rising edge and clears itself when the core pulses `take` while the reported level is the non-maskable level. Exception entry, vector generation and the processor state register are outside this block. The current level and the exception-mode flag arrive as inputs.

Top module: `irq_level_resolver`

## Requirements
- R1: While `rst` is high, `pend_valid`, `pend_level` and `pend_index` read zero and all request bits are cleared.
- R2: A level-type request bit (default: lines 0–5 and 12–30) follows its line with one register stage, so a line change shows at the outputs two cycles after it is applied.
- R3: The effective request set is the request bits ANDed with (enable OR non-maskable mask). The non-maskable line (default bit 31) is pending even when its enable bit is 0.
- R4: Only levels strictly above the threshold qualify, and the highest qualifying level wins. Line i has level (i mod 6)+1 for i < 31, and line 31 has level 7.
- R5: When `cur_level` is at or above the non-maskable level (7), the threshold becomes that level minus one, so a pending non-maskable request is still reported.
- R6: While `exc_mode` is 1, only the non-maskable source can be reported.
- R7: When several effective requests share the winning level, `pend_index` is the lowest-numbered of them.
- R8: When no level qualifies, `pend_valid` is 0 and `pend_level` and `pend_index` both read 0.
- R9: An edge-type bit (default lines 6–11) is set by a rising edge of its line and stays set after the line falls. `take` does not clear it. A 1 on its `sw_clr` bit clears it.
- R10: A `take` pulse while `pend_valid` is 1 and `pend_level` equals the non-maskable level clears the non-maskable request bit at that clock edge, unless a new rising edge arrives in the same cycle.
- R11: The outputs are registered. A change of `irq_en`, `cur_level` or `exc_mode` shows at the outputs one cycle after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_line | input | NUM_IRQ | Raw interrupt lines |
| sw_clr | input | NUM_IRQ | Software clear pulses for edge-type request bits |
| irq_en | input | NUM_IRQ | Per-line enable mask |
| cur_level | input | LW | Current interrupt level of the core |
| exc_mode | input | 1 | Exception-mode flag; blocks maskable sources |
| take | input | 1 | One-cycle acknowledge of the reported interrupt |
| pend_valid | output | 1 | An interrupt is pending |
| pend_level | output | LW | Level of the pending interrupt, 0 when none |
| pend_index | output | IW | Line index of the pending interrupt, 0 when none |

## Verification
A change on a line reaches the outputs two cycles later: one cycle for the request register and one for the output register. Changes to the enable mask, the current level or the exception flag reach the outputs one cycle later. The bench runs a cycle-accurate reference model that has the same two delays and compares the outputs at every falling edge. Its directed cases sample at exactly those cycles, including the cycle before a result is due, where the old value must still be present.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

  function automatic int unsigned top_level(input int unsigned num_lvl,
                                            input int unsigned nmi_lvl);
    return (nmi_lvl > num_lvl) ? nmi_lvl : num_lvl;
  endfunction

  function automatic int unsigned width_for(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int unsigned N = 32,
  parameter logic [N-1:0] EDGE_MASK = '0,
  parameter logic [N-1:0] NMI_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] line,
  input  logic [N-1:0] sw_clr,
  input  logic         nmi_ack,
  output logic [N-1:0] req_q
);
  localparam logic [N-1:0] LATCH_MASK = EDGE_MASK | NMI_MASK;

  logic [N-1:0] prev_q;
  logic [N-1:0] rise;
  logic [N-1:0] clr_vec;
  logic [N-1:0] nxt;

  assign rise    = line & ~prev_q;
  assign clr_vec = (sw_clr & EDGE_MASK & ~NMI_MASK) | (NMI_MASK & {N{nmi_ack}});
  assign nxt     = (~LATCH_MASK & line) |
                   (LATCH_MASK & (rise | (req_q & ~clr_vec)));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      req_q  <= '0;
    end else begin
      prev_q <= line;
      req_q  <= nxt;
    end
  end
endmodule

// File: rtl/irq_level_scan.sv
module irq_level_scan #(
  parameter int unsigned N = 32,
  parameter int unsigned LW = 3,
  parameter int unsigned IW = 5,
  parameter int unsigned TOP_LVL = 7,
  parameter int unsigned NMI_LVL = 7,
  parameter logic [N-1:0] NMI_MASK = '0,
  parameter int unsigned IRQ_LVL [N] = '{default: 1}
) (
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  en,
  input  logic [LW-1:0] cur,
  input  logic          exc,
  output logic          hit,
  output logic [LW-1:0] lvl,
  output logic [IW-1:0] idx
);
  logic [N-1:0]  eff;
  logic [LW-1:0] thr;
  logic [N-1:0]  lmask [TOP_LVL+1];
  logic [TOP_LVL:1] qual;
  logic [LW-1:0] win;
  logic [N-1:0]  sel;

  assign eff = exc ? (req & NMI_MASK) : (req & (en | NMI_MASK));
  assign thr = (cur >= LW'(NMI_LVL)) ? LW'(NMI_LVL - 1) : cur;

  for (genvar l = 0; l <= TOP_LVL; l++) begin : g_lvl
    for (genvar i = 0; i < N; i++) begin : g_bit
      assign lmask[l][i] = (IRQ_LVL[i] == l);
    end
  end

  for (genvar l = 1; l <= TOP_LVL; l++) begin : g_qual
    assign qual[l] = (LW'(l) > thr) && (|(eff & lmask[l]));
  end

  always_comb begin
    win = '0;
    for (int l = 1; l <= TOP_LVL; l++) begin
      if (qual[l]) win = LW'(l);
    end
  end

  assign sel = (win == '0) ? '0 : (eff & lmask[win]);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (sel[i]) idx = IW'(i);
    end
  end

  assign hit = |qual;
  assign lvl = win;
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver import irq_res_pkg::*; #(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned NUM_LVL = 6,
  parameter int unsigned NMI_LVL = 7,
  parameter logic [NUM_IRQ-1:0] NMI_MASK  = 32'h8000_0000,
  parameter logic [NUM_IRQ-1:0] EDGE_MASK = 32'h0000_0FC0,
  parameter int unsigned IRQ_LVL [NUM_IRQ] = '{
    1, 2, 3, 4, 5, 6, 1, 2, 3, 4, 5, 6, 1, 2, 3, 4,
    5, 6, 1, 2, 3, 4, 5, 6, 1, 2, 3, 4, 5, 6, 1, 7},
  localparam int unsigned TOP_LVL = top_level(NUM_LVL, NMI_LVL),
  localparam int unsigned LW = width_for(TOP_LVL),
  localparam int unsigned IW = width_for(NUM_IRQ - 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_line,
  input  logic [NUM_IRQ-1:0] sw_clr,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic [LW-1:0]      cur_level,
  input  logic               exc_mode,
  input  logic               take,
  output logic               pend_valid,
  output logic [LW-1:0]      pend_level,
  output logic [IW-1:0]      pend_index
);
  logic [NUM_IRQ-1:0] req_q;
  logic               nmi_ack;
  logic               scan_hit;
  logic [LW-1:0]      scan_lvl;
  logic [IW-1:0]      scan_idx;

  assign nmi_ack = take && pend_valid && (pend_level == LW'(NMI_LVL));

  irq_req_latch #(
    .N(NUM_IRQ), .EDGE_MASK(EDGE_MASK), .NMI_MASK(NMI_MASK)
  ) u_req (
    .clk(clk), .rst(rst), .line(irq_line), .sw_clr(sw_clr),
    .nmi_ack(nmi_ack), .req_q(req_q)
  );

  irq_level_scan #(
    .N(NUM_IRQ), .LW(LW), .IW(IW), .TOP_LVL(TOP_LVL), .NMI_LVL(NMI_LVL),
    .NMI_MASK(NMI_MASK), .IRQ_LVL(IRQ_LVL)
  ) u_scan (
    .req(req_q), .en(irq_en), .cur(cur_level), .exc(exc_mode),
    .hit(scan_hit), .lvl(scan_lvl), .idx(scan_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_level <= '0;
      pend_index <= '0;
    end else begin
      pend_valid <= scan_hit;
      pend_level <= scan_lvl;
      pend_index <= scan_idx;
    end
  end
endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
  parameter int unsigned N = 32,
  parameter int unsigned LW = 3,
  parameter int unsigned IW = 5,
  parameter int unsigned NMI_LVL = 7,
  parameter logic [N-1:0] NMI_MASK = '0,
  parameter logic [N-1:0] EDGE_MASK = '0
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  irq_line,
  input logic [N-1:0]  sw_clr,
  input logic [LW-1:0] cur_level,
  input logic          exc_mode,
  input logic          take,
  input logic [N-1:0]  req_q,
  input logic          pend_valid,
  input logic [LW-1:0] pend_level,
  input logic [IW-1:0] pend_index
);
  // R8: idle outputs read zero
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !pend_valid |-> (pend_level == '0 && pend_index == '0));

  // R4, R5: reported level lies above the clamped threshold of the previous cycle
  p_above_thr_r4: assert property (@(posedge clk) disable iff (rst)
    pend_valid |-> (pend_level >
      (($past(cur_level) >= LW'(NMI_LVL)) ? LW'(NMI_LVL - 1) : $past(cur_level))));

  // R6: exception mode lets only the non-maskable level through
  p_exc_nmi_only_r6: assert property (@(posedge clk) disable iff (rst)
    (pend_valid && $past(exc_mode)) |-> (pend_level == LW'(NMI_LVL)));

  // R10: acknowledged non-maskable request drops when no new edge arrives
  p_nmi_ack_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (take && pend_valid && pend_level == LW'(NMI_LVL) && ((irq_line & NMI_MASK) == '0))
      |=> ((req_q & NMI_MASK) == '0));

  // R9: a latched edge bit survives until its software clear
  p_edge_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (($past(req_q) & ~$past(sw_clr) & EDGE_MASK & ~req_q) == '0));
endmodule

bind irq_level_resolver irq_resolver_chk #(
  .N(NUM_IRQ), .LW(LW), .IW(IW), .NMI_LVL(NMI_LVL),
  .NMI_MASK(NMI_MASK), .EDGE_MASK(EDGE_MASK)
) u_chk (
  .clk(clk), .rst(rst), .irq_line(irq_line), .sw_clr(sw_clr),
  .cur_level(cur_level), .exc_mode(exc_mode), .take(take), .req_q(req_q),
  .pend_valid(pend_valid), .pend_level(pend_level), .pend_index(pend_index)
);

// File: tb/sim_irq_level_resolver.sv
`timescale 1ns/1ps
module sim_irq_level_resolver;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] line = '0;
  logic [31:0] clr = '0;
  logic [31:0] en = '0;
  logic [2:0]  cur = '0;
  logic        exc = 1'b0;
  logic        take = 1'b0;
  logic        pv;
  logic [2:0]  pl;
  logic [4:0]  pi;

  int total = 0;
  int bad = 0;

  irq_level_resolver u0 (
    .clk(clk), .rst(rst), .irq_line(line), .sw_clr(clr), .irq_en(en),
    .cur_level(cur), .exc_mode(exc), .take(take),
    .pend_valid(pv), .pend_level(pl), .pend_index(pi)
  );

  always #2 clk = ~clk;

  function automatic int lvl_of(input int i);
    return (i == 31) ? 7 : (i % 6) + 1;
  endfunction

  function automatic logic [8:0] resolve(input logic [31:0] rq, input logic [31:0] msk,
                                         input logic [2:0] c, input logic x);
    logic [31:0] e;
    int th;
    e = rq & (msk | 32'h8000_0000);
    if (x) e = e & 32'h8000_0000;
    th = (c >= 3'd7) ? 6 : int'(c);
    for (int l = 7; l > th; l--)
      for (int i = 0; i < 32; i++)
        if (e[i] && lvl_of(i) == l) return {1'b1, 3'(l), 5'(i)};
    return 9'd0;
  endfunction

  // reference model: request register then output register
  logic [31:0] m_req, m_prev;
  logic        e_v;
  logic [2:0]  e_l;
  logic [4:0]  e_i;

  always @(posedge clk) begin
    logic [31:0] nreq;
    logic ack;
    if (rst) begin
      m_req <= '0; m_prev <= '0; e_v <= 1'b0; e_l <= '0; e_i <= '0;
    end else begin
      ack = take && e_v && (e_l == 3'd7);
      for (int i = 0; i < 32; i++) begin
        if (i == 31)
          nreq[i] = (line[i] & ~m_prev[i]) | (m_req[i] & ~ack);
        else if (i >= 6 && i <= 11)
          nreq[i] = (line[i] & ~m_prev[i]) | (m_req[i] & ~clr[i]);
        else
          nreq[i] = line[i];
      end
      {e_v, e_l, e_i} <= resolve(m_req, en, cur, exc);
      m_req  <= nreq;
      m_prev <= line;
    end
  end

  task automatic check(input string tag, input logic v, input logic [2:0] l, input logic [4:0] i);
    total++;
    if (pv !== v || pl !== l || pi !== i) begin
      bad++;
      $display("FAIL %s: got v=%0d lvl=%0d idx=%0d exp v=%0d lvl=%0d idx=%0d",
               tag, pv, pl, pi, v, l, i);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    @(negedge clk);
    check(tag, e_v, e_l, e_i);
  endtask

  task automatic flush();
    line = '0; clr = '1; en = '0; cur = '0; exc = 1'b0; take = 1'b1;
    repeat (4) tick("R10 flush");
    clr = '0; take = 1'b0;
    tick("R10 flush");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got hang exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] s;
    s = 32'h1234_5678;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", 1'b0, 3'd0, 5'd0);
    rst = 1'b0;
    tick("R1");

    // single-line sweep over every line and current level
    for (int i = 0; i < 32; i++) begin
      for (int c = 0; c < 8; c++) begin
        line = 32'd1 << i; en = '1; cur = 3'(c);
        tick("R2 R4 R5"); tick("R2 R4 R5");
        line = '0; clr = '1; take = 1'b1;
        tick("R9 R10"); clr = '0; take = 1'b0;
        tick("R2 R4");
      end
    end

    // pseudo-random patterns over all controls
    for (int k = 0; k < 600; k++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      line = s;
      en   = {s[15:0], s[31:16]} ^ 32'h5A5A_A5A5;
      cur  = 3'(k % 8);
      exc  = (k % 4 == 0);
      take = (k % 7 == 0);
      clr  = (k % 9 == 0) ? s : '0;
      tick("R3 R4 R6 R7 R11");
    end

    // R8: nothing enabled, no non-maskable request
    flush();
    line = 32'h7FFF_F03F; en = '0;
    tick("R8"); tick("R8");
    check("R8 none enabled", 1'b0, 3'd0, 5'd0);
    en = '1; cur = 3'd7;
    tick("R8");
    check("R8 above threshold", 1'b0, 3'd0, 5'd0);

    // R7: tie at level 1
    flush();
    line = (32'd1 << 18) | (32'd1 << 24); en = '1;
    tick("R7"); tick("R7");
    check("R7 tie", 1'b1, 3'd1, 5'd18);
    line = line | (32'd1 << 12);
    tick("R7"); tick("R7");
    check("R7 lower joins", 1'b1, 3'd1, 5'd12);

    // R3 R5 R6: non-maskable beats everything
    flush();
    en = '0; cur = 3'd7; exc = 1'b1;
    line = 32'h80FF_F03F;
    tick("R5"); tick("R5");
    check("R3 R5 R6 nmi", 1'b1, 3'd7, 5'd31);
    take = 1'b1;
    tick("R10");
    check("R10 take cycle", 1'b1, 3'd7, 5'd31);
    take = 1'b0;
    tick("R10");
    check("R10 auto clear", 1'b0, 3'd0, 5'd0);

    // R11: one-cycle response to control changes
    flush();
    line = 32'd1 << 5; en = '1;
    tick("R11"); tick("R11");
    check("R11 base", 1'b1, 3'd6, 5'd5);
    cur = 3'd6;
    tick("R11");
    check("R11 cur raised", 1'b0, 3'd0, 5'd0);
    cur = 3'd5;
    tick("R11");
    check("R11 cur lowered", 1'b1, 3'd6, 5'd5);
    en = '0;
    tick("R11");
    check("R11 disabled", 1'b0, 3'd0, 5'd0);
    en = '1; exc = 1'b1;
    tick("R6");
    check("R6 exc blocks", 1'b0, 3'd0, 5'd0);
    exc = 1'b0;

    // R2: two-cycle latency from the line
    flush();
    line = 32'd1 << 4; en = '1;
    tick("R2");
    check("R2 not yet", 1'b0, 3'd0, 5'd0);
    tick("R2");
    check("R2 due", 1'b1, 3'd5, 5'd4);
    line = '0;
    tick("R2");
    check("R2 fall pending", 1'b1, 3'd5, 5'd4);
    tick("R2");
    check("R2 fall due", 1'b0, 3'd0, 5'd0);

    // R9: edge bit latch, take ignored, software clear
    flush();
    en = '1;
    line = 32'd1 << 8;
    tick("R9");
    line = '0;
    tick("R9");
    check("R9 latched", 1'b1, 3'd3, 5'd8);
    tick("R9"); tick("R9");
    check("R9 held", 1'b1, 3'd3, 5'd8);
    take = 1'b1;
    tick("R9");
    take = 1'b0;
    tick("R9");
    check("R9 take no effect", 1'b1, 3'd3, 5'd8);
    clr = 32'd1 << 8;
    tick("R9");
    clr = '0;
    tick("R9");
    check("R9 cleared", 1'b0, 3'd0, 5'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule